// File: doc/BRIEF.md
# Software-Raised Interrupt Status Controller

This block keeps a 32-bit word of pending interrupt causes and drives one level-sensitive interrupt line from it. A cause bit becomes set in one of two ways: software writes a word to the raise register, or an internal source sends a one-cycle pulse on its own lane of a per-cause set vector. Software clears cause bits by writing a word to the acknowledge register. Every bit written as one in that word is cleared.

The pending word can be read back. The interrupt line stays high for as long as any pending bit is set. It falls only once software has acknowledged every bit that was set. The register port is a simple one-cycle slave with a write strobe, a read strobe, a byte offset and an access size. Read data is registered, so it appears one cycle after the read strobe. The set-pulse vector is a plain control input and has no handshake.

Top module: `irq_softraise`

## Requirements
- R1: After reset the pending word is zero and `irq_o` is low.
- R2: A 4-byte write to offset 0x60 ORs the written data into the pending word. The new word is visible from the next cycle.
- R3: A 4-byte write to offset 0x64 clears each pending bit whose data bit is one. All other pending bits are unchanged.
- R4: A 4-byte read at offset 0x24 returns the pending word on `rdata_o` in the cycle after `rd_i`. A read at any other offset returns zero.
- R5: `irq_o` is high in every cycle in which the pending word is nonzero, and low in every cycle in which it is zero.
- R6: A one-cycle pulse on lane k of `hw_set_i` sets pending bit k in the next cycle. The factorial-done source uses lane 0 (0x00000001), and the DMA-done source uses lane 8 (0x00000100).
- R7: If a hardware set pulse and an acknowledge of the same bit arrive in the same cycle, the bit ends up set.
- R8: A write whose `size_i` is not 4 (encoding: `size_i` gives the byte count) leaves the pending word unchanged. This holds at offset 0x60 and at offset 0x64.
- R9: Writes to offsets other than 0x60 and 0x64 leave the pending word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| addr_i | input | 8 | Byte offset |
| size_i | input | 4 | Access size in bytes |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| hw_set_i | input | 32 | Per-cause hardware set pulses |
| irq_o | output | 1 | Level interrupt line |

## Verification
The bench builds the block with its default parameters: a 32-bit word and an 8-bit offset. These defaults bring the top bit (bit 31), both source lanes (0 and 8) and the full range of wrong access sizes within reach. A vector table steps through raise, acknowledge, hardware set pulses and rejected accesses. The table is followed by directed tests of the set-versus-acknowledge collision and of the exact cycle in which the line falls.

// File: rtl/irq_softraise_pkg.sv
package irq_softraise_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_RAISE = 2'd1,
    OP_ACK   = 2'd2
  } irq_op_e;
endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
  import irq_softraise_pkg::*;
#(
  parameter int AW = 8,
  parameter int SW = 4,
  parameter logic [AW-1:0] RAISE_OFF = 8'h60,
  parameter logic [AW-1:0] ACK_OFF = 8'h64,
  parameter logic [AW-1:0] STAT_OFF = 8'h24,
  parameter int WORD_BYTES = 4
) (
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [AW-1:0] addr_i,
  input  logic [SW-1:0] size_i,
  output irq_op_e       op_o,
  output logic          rd_stat_o
);
  localparam logic [SW-1:0] WordSz = SW'(WORD_BYTES);
  logic size_ok;
  assign size_ok = (size_i == WordSz);
  always_comb begin
    op_o = OP_NONE;
    if (wr_i && size_ok) begin
      if (addr_i == RAISE_OFF) op_o = OP_RAISE;
      else if (addr_i == ACK_OFF) op_o = OP_ACK;
    end
  end
  assign rd_stat_o = rd_i && size_ok && (addr_i == STAT_OFF);
endmodule

// File: rtl/irq_status_bits.sv
module irq_status_bits
  import irq_softraise_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  irq_op_e       op_i,
  input  logic [DW-1:0] data_i,
  input  logic [DW-1:0] hw_set_i,
  output logic [DW-1:0] pend_o
);
  for (genvar k = 0; k < DW; k++) begin : g_bit
    logic sw_set, sw_clr;
    assign sw_set = (op_i == OP_RAISE) && data_i[k];
    assign sw_clr = (op_i == OP_ACK) && data_i[k];
    always_ff @(posedge clk_i) begin
      if (!rst_ni) pend_o[k] <= 1'b0;
      else if (hw_set_i[k] || sw_set) pend_o[k] <= 1'b1;
      else if (sw_clr) pend_o[k] <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_softraise.sv
module irq_softraise
  import irq_softraise_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 8,
  parameter int SW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [AW-1:0] addr_i,
  input  logic [SW-1:0] size_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic [DW-1:0] hw_set_i,
  output logic          irq_o
);
  irq_op_e       op;
  logic          rd_stat;
  logic [DW-1:0] pend;

  irq_reg_decode #(.AW(AW), .SW(SW)) u_dec (
    .wr_i(wr_i), .rd_i(rd_i), .addr_i(addr_i), .size_i(size_i),
    .op_o(op), .rd_stat_o(rd_stat)
  );

  irq_status_bits #(.DW(DW)) u_bits (
    .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op), .data_i(wdata_i),
    .hw_set_i(hw_set_i), .pend_o(pend)
  );

  always_ff @(posedge clk_i) begin
    if (!rst_ni) rdata_o <= '0;
    else if (rd_stat) rdata_o <= pend;
    else rdata_o <= '0;
  end

  assign irq_o = |pend;
endmodule

// File: rtl/irq_softraise_chk.sv
module irq_softraise_chk #(
  parameter int DW = 32,
  parameter int AW = 8,
  parameter int SW = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_i,
  input logic [AW-1:0] addr_i,
  input logic [SW-1:0] size_i,
  input logic [DW-1:0] wdata_i,
  input logic [DW-1:0] hw_set_i,
  input logic [DW-1:0] pend,
  input logic          irq_o
);
  // R5
  line_matches_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (pend != '0));
  // R2
  raise_sets_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && size_i == SW'(4) && addr_i == AW'(8'h60)) |=> ((pend & $past(wdata_i)) == $past(wdata_i)));
  // R6
  hw_pulse_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hw_set_i != '0) |=> ((pend & $past(hw_set_i)) == $past(hw_set_i)));
  // R8
  bad_size_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && size_i != SW'(4) && hw_set_i == '0) |=> $stable(pend));
  // R3
  ack_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && size_i == SW'(4) && addr_i == AW'(8'h64) && hw_set_i == '0)
      |=> ((pend & $past(wdata_i)) == '0));
endmodule

bind irq_softraise irq_softraise_chk #(.DW(DW), .AW(AW), .SW(SW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .addr_i(addr_i),
  .size_i(size_i), .wdata_i(wdata_i), .hw_set_i(hw_set_i),
  .pend(pend), .irq_o(irq_o)
);

// File: tb/tb_irq_softraise.sv
module tb_irq_softraise;
  localparam int CLK_PERIOD = 10;
  logic clk = 0, rst_n = 0;
  logic wr = 0, rd = 0;
  logic [7:0] addr = 0;
  logic [3:0] size = 0;
  logic [31:0] wdata = 0, hw = 0;
  logic [31:0] rdata;
  logic irq;
  int errs = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_softraise dut (.clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .rd_i(rd),
    .addr_i(addr), .size_i(size), .wdata_i(wdata), .rdata_o(rdata),
    .hw_set_i(hw), .irq_o(irq));

  // vector: addr, size, data, hw, expected pending word afterwards
  typedef struct packed { logic [7:0] a; logic [3:0] s; logic [31:0] d; logic [31:0] h; logic [31:0] e; } vec_t;
  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{8'h60, 4'd4, 32'h8000_0003, 32'h0, 32'h8000_0003}, // R2
    '{8'h60, 4'd4, 32'h0000_0010, 32'h0, 32'h8000_0013}, // R2
    '{8'h64, 4'd4, 32'h0000_0002, 32'h0, 32'h8000_0011}, // R3
    '{8'h60, 4'd8, 32'h0000_F000, 32'h0, 32'h8000_0011}, // R8
    '{8'h64, 4'd2, 32'hFFFF_FFFF, 32'h0, 32'h8000_0011}, // R8
    '{8'h24, 4'd4, 32'hFFFF_FFFF, 32'h0, 32'h8000_0011}, // R9
    '{8'h00, 4'd0, 32'h0,         32'h0000_0100, 32'h8000_0111}, // R6 DMA lane
    '{8'h64, 4'd4, 32'h8000_0111, 32'h0, 32'h0},          // R3
    '{8'h00, 4'd0, 32'h0,         32'h0000_0001, 32'h1}   // R6 factorial lane
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic w, input logic [7:0] a, input logic [3:0] s,
                      input logic [31:0] d, input logic [31:0] h);
    wr = w; addr = a; size = s; wdata = d; hw = h;
    @(posedge clk); #1;
    wr = 0; hw = 0;
  endtask

  task automatic read_stat(output logic [31:0] v);
    rd = 1; addr = 8'h24; size = 4;
    @(posedge clk); #1;
    rd = 0;
    v = rdata;
  endtask

  initial begin
    #(CLK_PERIOD*20000);
    errs++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk); #1;
    rst_n = 1;
    read_stat(v);
    chk("R1 reset word", v, 32'h0);
    chk("R1 reset irq", {31'h0, irq}, 32'h0);
    for (int i = 0; i < NV; i++) begin
      step(VEC[i].h != 0 ? 1'b0 : 1'b1, VEC[i].a, VEC[i].s, VEC[i].d, VEC[i].h);
      read_stat(v);
      chk($sformatf("R4 vector %0d", i), v, VEC[i].e);
      chk($sformatf("R5 vector %0d", i), {31'h0, irq}, {31'h0, VEC[i].e != 0});
    end
    // R4 other offset reads zero
    rd = 1; addr = 8'h20; size = 4; @(posedge clk); #1; rd = 0;
    chk("R4 other offset", rdata, 32'h0);
    // R7 collision: ack bit 8 while hw sets bit 8
    step(1, 8'h64, 4, 32'h0000_0101, 32'h0000_0100);
    read_stat(v);
    chk("R7 set wins", v, 32'h0000_0100);
    // R5 line falls exactly after last ack
    step(1, 8'h64, 4, 32'h0000_0100, 0);
    chk("R5 line low after ack", {31'h0, irq}, 32'h0);
    step(1, 8'h60, 4, 32'h0000_0004, 0);
    chk("R5 line high after raise", {31'h0, irq}, 32'h1);
    // R1 reset clears
    rst_n = 0; @(posedge clk); #1; rst_n = 1;
    read_stat(v);
    chk("R1 reset clears word", v, 32'h0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule